// File: doc/BRIEF.md
# Predicated Vector Element Step Skipper

This block runs ahead of each element operation of a vector instruction. It receives the current source element index, the current destination element index, the vector length (VL) and two already-resolved 64-bit predicate masks. For each side on its own, it moves the index forward to the next element whose predicate bit is set. If no such element exists below VL, the index stops at VL, and an index equal to VL means that the element loop is exhausted and the next instruction follows. A side that has zeroing enabled never skips. It stays on its current element and raises a zero flag when that element's predicate bit is clear.

A pulse on `start` captures the indices, VL, masks, mode and zeroing controls. The block then tests one candidate element per clock on both sides in parallel. It raises `done` once both sides have settled and keeps the results until the next accepted start. A two-bit mode picks the predication style. With no predication, both masks count as all ones. With single predication, both sides use the destination mask. With twin predication, the source side uses its own mask.

The controller has three states. In IDLE nothing has been requested since reset. In SCAN one candidate per side is tested each cycle. DONE holds the results. The transitions are: IDLE or DONE to SCAN on start with VL nonzero, IDLE or DONE to DONE on start with VL zero, SCAN to DONE when both sides are settled, and SCAN to SCAN otherwise. A start pulse in SCAN is ignored.

Top module: `pred_step_skip`

## Requirements
- R1: After reset, `busy`, `done`, `src_zero` and `dst_zero` are 0 and both output indices are 0.
- R2: The mode encoding is as follows. `pred_mode` 2'b00 (none) and 2'b11 (reserved) treat both masks as all ones. 2'b01 (single) uses `dst_mask_in` for both sides. 2'b10 (twin) uses `src_mask_in` for the source side and `dst_mask_in` for the destination side.
- R3: With source zeroing off, the source index advances from its start value while the selected mask bit at the index is 0 and the index is below VL. The final index is the first index at or above the start value whose bit is 1, or VL if there is none.
- R4: The destination index follows the rule in R3 using its own mask and zeroing control, independently of the source side.
- R5: With zeroing on for a side, that side's index is returned unchanged. Its zero flag is 1 exactly when the index is below VL and the mask bit at that index is 0. A side with zeroing off always reports a zero flag of 0.
- R6: Mask bits at or above VL have no effect. An index whose start value is at or above VL is returned unchanged, with a zero flag of 0.
- R7: The block tests one candidate per clock. Let n be the larger of the two sides' skip counts. When VL is nonzero, `done` rises n+1 clock edges after the edge that samples `start`. `busy` is 1 between the sampling edge and the edge at which `done` rises.
- R8: When VL is zero, `done` is 1 right after the edge that samples `start`. Both indices are unchanged and both zero flags are 0.
- R9: Results and `done` hold until the next start. Input changes without a start do not alter them, and a start pulse while `busy` is 1 is ignored.
- R10: When VL is above 64, bits at index 64 or higher count as 0. Scanning continues to VL, and a zeroing side at such an index below VL reports a zero flag of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; captures all inputs when not busy |
| pred_mode | input | 2 | Predication style: 00 none, 01 single, 10 twin, 11 treated as none |
| src_idx_in | input | 7 | Current source element index |
| dst_idx_in | input | 7 | Current destination element index |
| vl_in | input | 7 | Vector length |
| src_mask_in | input | 64 | Source predicate mask, used in twin mode only |
| dst_mask_in | input | 64 | Destination predicate mask |
| src_zero_en | input | 1 | Source zeroing enable |
| dst_zero_en | input | 1 | Destination zeroing enable |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Results valid, held until the next start |
| src_idx_out | output | 7 | New source element index |
| dst_idx_out | output | 7 | New destination element index |
| src_zero | output | 1 | Source element must be zeroed |
| dst_zero | output | 1 | Destination element must be zeroed |

## Verification
For each request the bench works out both sides' skip counts from the mask, the start index and VL. From these it takes the number of edges until `done` must rise: none beyond the sampling edge when VL is zero, and the larger skip count plus one otherwise. Each scoreboard entry records the cycle of its sampling edge and the cycle at which `done` is due. The monitor samples on the falling edge and only accepts a result after the sampling edge. It compares the cycle of arrival as well as the indices and flags, so an early or late `done` counts as a miscompare. The ignored-start and hold cases re-read the outputs after the disturbing stimulus and before the next accepted start.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } pss_state_t;

    localparam logic [1:0] PM_NONE   = 2'b00;
    localparam logic [1:0] PM_SINGLE = 2'b01;
    localparam logic [1:0] PM_TWIN   = 2'b10;
    localparam logic [1:0] PM_RSVD   = 2'b11;

    localparam int SIDE_SRC  = 0;
    localparam int SIDE_DST  = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/pss_mask_sel.sv
module pss_mask_sel
    import pss_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic [1:0]        mode,
    input  logic [MASK_W-1:0] src_mask_raw,
    input  logic [MASK_W-1:0] dst_mask_raw,
    output logic [MASK_W-1:0] src_mask_eff,
    output logic [MASK_W-1:0] dst_mask_eff
);

    localparam logic [MASK_W-1:0] ALL_ONES = {MASK_W{1'b1}};

    always_comb begin
        unique case (mode)
            PM_SINGLE: begin
                src_mask_eff = dst_mask_raw;
                dst_mask_eff = dst_mask_raw;
            end
            PM_TWIN: begin
                src_mask_eff = src_mask_raw;
                dst_mask_eff = dst_mask_raw;
            end
            PM_NONE, PM_RSVD: begin
                src_mask_eff = ALL_ONES;
                dst_mask_eff = ALL_ONES;
            end
            default: begin
                src_mask_eff = ALL_ONES;
                dst_mask_eff = ALL_ONES;
            end
        endcase
    end

endmodule

// File: rtl/pss_side_scan.sv
module pss_side_scan #(
    parameter int IDX_W  = 7,
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              scan,
    input  logic [IDX_W-1:0]  idx_init,
    input  logic [MASK_W-1:0] mask_init,
    input  logic              zero_en_init,
    input  logic [IDX_W-1:0]  vl_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              settled,
    output logic              zero_flag
);

    localparam int SEL_W = $clog2(MASK_W);
    localparam logic [IDX_W:0] MASK_LIMIT = (IDX_W+1)'(MASK_W);

    logic [MASK_W-1:0] mask_q;
    logic              zero_en_q;
    logic              in_mask;
    logic              below_vl;
    logic              cur_bit;

    // Capture and step register for this side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            mask_q    <= '0;
            zero_en_q <= 1'b0;
        end else if (load) begin
            idx_q     <= idx_init;
            mask_q    <= mask_init;
            zero_en_q <= zero_en_init;
        end else if (scan && !settled) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Candidate bit lookup; indices past the mask width read as clear
    always_comb begin
        in_mask  = ({1'b0, idx_q} < MASK_LIMIT);
        below_vl = (idx_q < vl_q);
        cur_bit  = in_mask ? mask_q[idx_q[SEL_W-1:0]] : 1'b0;
        settled  = zero_en_q || !below_vl || cur_bit;
        zero_flag = zero_en_q && below_vl && !cur_bit;
    end

    // R3: an unsettled side moves exactly one element per scan cycle
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && !load && !settled) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

    // R5: a zeroing side never moves while scanning
    assert_zero_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && !load && zero_en_q) |=> $stable(idx_q));

    // R9: without load or scan the index holds
    assert_idx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !scan) |=> $stable(idx_q));

    // R6: a side never walks past VL
    assert_no_pass_vl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && !load && (idx_q >= vl_q)) |=> $stable(idx_q));

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
    import pss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic vl_zero,
    input  logic all_settled,
    output logic load,
    output logic scan,
    output logic busy,
    output logic done
);

    pss_state_t state_q;
    pss_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = vl_zero ? ST_DONE : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (all_settled) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        load = 1'b0;
        scan = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = start;
            end
            ST_SCAN: begin
                scan = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                load = start;
                done = 1'b1;
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

    // R7: settled scan finishes on the next edge
    assert_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && all_settled) |=> done);

    // R7: busy and done are never high together
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8: a zero-length request completes on the sampling edge
    assert_vl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && vl_zero) |=> done);

    // R9: done holds until a new start is accepted
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/pred_step_skip.sv
module pred_step_skip
    import pss_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        pred_mode,
    input  logic [IDX_W-1:0]  src_idx_in,
    input  logic [IDX_W-1:0]  dst_idx_in,
    input  logic [IDX_W-1:0]  vl_in,
    input  logic [MASK_W-1:0] src_mask_in,
    input  logic [MASK_W-1:0] dst_mask_in,
    input  logic              src_zero_en,
    input  logic              dst_zero_en,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  src_idx_out,
    output logic [IDX_W-1:0]  dst_idx_out,
    output logic              src_zero,
    output logic              dst_zero
);

    logic              load;
    logic              scan;
    logic              all_settled;
    logic [IDX_W-1:0]  vl_q;
    logic [MASK_W-1:0] src_mask_eff;
    logic [MASK_W-1:0] dst_mask_eff;

    logic [IDX_W-1:0]  side_idx_init [NUM_SIDES];
    logic [MASK_W-1:0] side_mask_init[NUM_SIDES];
    logic              side_zen_init [NUM_SIDES];
    logic [IDX_W-1:0]  side_idx      [NUM_SIDES];
    logic              side_settled  [NUM_SIDES];
    logic              side_zero     [NUM_SIDES];

    // Captured vector length, shared by both sides
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q <= '0;
        end else if (load) begin
            vl_q <= vl_in;
        end
    end

    pss_mask_sel #(
        .MASK_W (MASK_W)
    ) mask_sel_i (
        .mode         (pred_mode),
        .src_mask_raw (src_mask_in),
        .dst_mask_raw (dst_mask_in),
        .src_mask_eff (src_mask_eff),
        .dst_mask_eff (dst_mask_eff)
    );

    always_comb begin
        side_idx_init[SIDE_SRC]  = src_idx_in;
        side_idx_init[SIDE_DST]  = dst_idx_in;
        side_mask_init[SIDE_SRC] = src_mask_eff;
        side_mask_init[SIDE_DST] = dst_mask_eff;
        side_zen_init[SIDE_SRC]  = src_zero_en;
        side_zen_init[SIDE_DST]  = dst_zero_en;
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        pss_side_scan #(
            .IDX_W  (IDX_W),
            .MASK_W (MASK_W)
        ) side_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .load         (load),
            .scan         (scan),
            .idx_init     (side_idx_init[g]),
            .mask_init    (side_mask_init[g]),
            .zero_en_init (side_zen_init[g]),
            .vl_q         (vl_q),
            .idx_q        (side_idx[g]),
            .settled      (side_settled[g]),
            .zero_flag    (side_zero[g])
        );
    end

    assign all_settled = side_settled[SIDE_SRC] && side_settled[SIDE_DST];

    pss_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vl_zero     (vl_in == '0),
        .all_settled (all_settled),
        .load        (load),
        .scan        (scan),
        .busy        (busy),
        .done        (done)
    );

    assign src_idx_out = side_idx[SIDE_SRC];
    assign dst_idx_out = side_idx[SIDE_DST];
    assign src_zero    = side_zero[SIDE_SRC];
    assign dst_zero    = side_zero[SIDE_DST];

    // R9: while done is held without start the results stay put
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(src_idx_out) && $stable(dst_idx_out)
                              && $stable(src_zero) && $stable(dst_zero)));

endmodule

// File: tb/pred_step_skip_tb_top.sv
module pred_step_skip_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  pred_mode = 2'b00;
    logic [6:0]  src_idx_in = '0;
    logic [6:0]  dst_idx_in = '0;
    logic [6:0]  vl_in = '0;
    logic [63:0] src_mask_in = '0;
    logic [63:0] dst_mask_in = '0;
    logic        src_zero_en = 1'b0;
    logic        dst_zero_en = 1'b0;
    logic        busy, done, src_zero, dst_zero;
    logic [6:0]  src_idx_out, dst_idx_out;

    always #5 clk = ~clk;

    pred_step_skip dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pred_mode(pred_mode),
        .src_idx_in(src_idx_in), .dst_idx_in(dst_idx_in), .vl_in(vl_in),
        .src_mask_in(src_mask_in), .dst_mask_in(dst_mask_in),
        .src_zero_en(src_zero_en), .dst_zero_en(dst_zero_en),
        .busy(busy), .done(done), .src_idx_out(src_idx_out),
        .dst_idx_out(dst_idx_out), .src_zero(src_zero), .dst_zero(dst_zero)
    );

    typedef struct {
        logic [6:0] s_idx;
        logic [6:0] d_idx;
        logic       s_z;
        logic       d_z;
        int         start_cyc;
        int         exp_cyc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   vectors = 0;
    int   miscompares = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    function automatic void model(input logic [6:0] i0, input logic [6:0] vl,
                                  input logic [63:0] m, input logic zen,
                                  output logic [6:0] idx, output logic flg,
                                  output int skips);
        int i;
        i = int'(i0);
        skips = 0;
        flg = 1'b0;
        if (zen) begin
            if (i < int'(vl)) flg = (i < 64) ? !m[i] : 1'b1;
        end else begin
            while (i < int'(vl) && !(i < 64 && m[i])) begin
                i++;
                skips++;
            end
        end
        idx = 7'(i);
    endfunction

    // Monitor: pops and compares once done is seen after the sampling edge
    always @(negedge clk) begin
        if (q.size() > 0 && cyc > q[0].start_cyc && done) begin
            exp_t it;
            it = q.pop_front();
            vectors++;
            if (src_idx_out !== it.s_idx || dst_idx_out !== it.d_idx ||
                src_zero !== it.s_z || dst_zero !== it.d_z || cyc != it.exp_cyc) begin
                miscompares++;
                $display("FAIL %s: got src=%0d dst=%0d sz=%0b dz=%0b cyc=%0d, expected src=%0d dst=%0d sz=%0b dz=%0b cyc=%0d",
                         it.tag, src_idx_out, dst_idx_out, src_zero, dst_zero, cyc,
                         it.s_idx, it.d_idx, it.s_z, it.d_z, it.exp_cyc);
            end
        end
    end

    // Driver: computes expectations, pushes them, and pulses start
    task automatic apply(input logic [1:0] mode, input logic [6:0] si, input logic [6:0] di,
                         input logic [6:0] vl, input logic [63:0] sm, input logic [63:0] dm,
                         input logic sz, input logic dz, input string tag, input bit disturb);
        logic [63:0] es, ed;
        exp_t it;
        int ns, nd, lat;
        case (mode)
            2'b01:   begin es = dm; ed = dm; end
            2'b10:   begin es = sm; ed = dm; end
            default: begin es = '1; ed = '1; end
        endcase
        model(si, vl, es, sz, it.s_idx, it.s_z, ns);
        model(di, vl, ed, dz, it.d_idx, it.d_z, nd);
        lat = (vl == 0) ? 0 : ((ns > nd) ? ns : nd) + 1;
        it.tag = tag;
        @(negedge clk);
        pred_mode = mode; src_idx_in = si; dst_idx_in = di; vl_in = vl;
        src_mask_in = sm; dst_mask_in = dm; src_zero_en = sz; dst_zero_en = dz;
        start = 1'b1;
        it.start_cyc = cyc;
        it.exp_cyc = cyc + 1 + lat;
        q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            @(negedge clk);
            pred_mode = 2'b00; src_idx_in = 7'd1; dst_idx_in = 7'd2; vl_in = 7'd3;
            src_zero_en = 1'b1; dst_zero_en = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    // R9: inputs change without start; outputs must not move
    task automatic check_hold();
        logic [6:0] s0, d0;
        logic z0, z1;
        s0 = src_idx_out; d0 = dst_idx_out; z0 = src_zero; z1 = dst_zero;
        @(negedge clk);
        src_idx_in = 7'd33; dst_idx_in = 7'd44; vl_in = 7'd90;
        src_mask_in = '0; dst_mask_in = '0; src_zero_en = 1'b1; pred_mode = 2'b10;
        repeat (5) @(negedge clk);
        vectors++;
        if (src_idx_out !== s0 || dst_idx_out !== d0 || src_zero !== z0 ||
            dst_zero !== z1 || done !== 1'b1) begin
            miscompares++;
            $display("FAIL R9 hold: got src=%0d dst=%0d sz=%0b dz=%0b done=%0b, expected src=%0d dst=%0d sz=%0b dz=%0b done=1",
                     src_idx_out, dst_idx_out, src_zero, dst_zero, done, s0, d0, z0, z1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got no completion, expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (busy !== 1'b0 || done !== 1'b0 || src_idx_out !== 7'd0 || dst_idx_out !== 7'd0 ||
            src_zero !== 1'b0 || dst_zero !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset: got busy=%0b done=%0b src=%0d dst=%0d sz=%0b dz=%0b, expected all zero",
                     busy, done, src_idx_out, dst_idx_out, src_zero, dst_zero);
        end
        rst_n = 1'b1;
        @(negedge clk);

        apply(2'b00, 7'd3, 7'd5, 7'd10, 64'h0, 64'h0, 1'b0, 1'b0, "R2 none mode all ones", 1'b0);
        apply(2'b11, 7'd4, 7'd6, 7'd10, 64'h0, 64'h0, 1'b0, 1'b0, "R2 reserved mode as none", 1'b0);
        apply(2'b01, 7'd2, 7'd0, 7'd20, '1, 64'h80, 1'b0, 1'b0, "R2 R3 single mode shares dst mask", 1'b0);
        apply(2'b10, 7'd0, 7'd0, 7'd16, 64'h10, 64'h200, 1'b0, 1'b0, "R3 R4 twin independent skip", 1'b0);
        apply(2'b10, 7'd1, 7'd2, 7'd12, 64'h1000, 64'h4, 1'b0, 1'b0, "R6 bits above VL ignored", 1'b0);
        apply(2'b10, 7'd5, 7'd0, 7'd20, 64'h0, 64'h100, 1'b1, 1'b0, "R5 src zeroing flags clear bit", 1'b0);
        apply(2'b10, 7'd5, 7'd3, 7'd20, 64'h20, 64'h8, 1'b1, 1'b1, "R5 zeroing with set bits", 1'b0);
        apply(2'b10, 7'd20, 7'd15, 7'd10, 64'h0, 64'h0, 1'b1, 1'b0, "R6 start index at or above VL", 1'b0);
        apply(2'b10, 7'd9, 7'd4, 7'd0, 64'h0, 64'h0, 1'b1, 1'b1, "R8 VL zero", 1'b0);
        apply(2'b10, 7'd7, 7'd8, 7'd0, 64'h0, 64'h0, 1'b0, 1'b0, "R8 VL zero again from done", 1'b0);
        apply(2'b10, 7'd60, 7'd62, 7'd100, 64'h0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R10 scan past bit 63 to VL", 1'b0);
        apply(2'b10, 7'd70, 7'd65, 7'd100, '1, '1, 1'b1, 1'b0, "R10 R5 zeroing beyond mask width", 1'b0);
        apply(2'b01, 7'd0, 7'd1, 7'd40, 64'h0, 64'h10_0000, 1'b0, 1'b0, "R7 R9 start during scan ignored", 1'b1);
        check_hold();
        apply(2'b10, 7'd0, 7'd30, 7'd50, 64'h1, 64'h0, 1'b0, 1'b0, "R7 latency set by longer side", 1'b0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule